// File: doc/BRIEF.md
# Signed Event Code Admission Filter

This block decides whether a signed error or event number may go on into an error queue. It holds a small programmable list of admission entries. Each entry is either one exact code or an inclusive band of codes. A host loads the entries one at a time through a write port and empties the list with a clear input. A code presented with a strobe gets a registered admit or reject answer on the following cycle. The answer is admit when the code matches any stored entry.

A write is checked as it arrives. A band whose lower bound is not strictly below its upper bound is refused. A write that would add a seventh entry is also refused. In both cases the table stays unchanged and a single-cycle error pulse follows. A read port, indexed by slot, shows what each stored entry holds so that the host can confirm the list.

Top module: `evgate_filter`

## Requirements
- R1: The table holds at most 6 entries. Accepted writes fill slots 0, 1, 2 and so on in the order they arrive.
- R2: A single entry (wr_rng=0) admits only the code that equals its value.
- R3: A band write (wr_rng=1) with wr_lo >= wr_hi, compared as signed numbers, is refused. It leaves the table unchanged and drives wr_err high for exactly the one cycle after the write.
- R4: Codes and bounds are 16-bit two's complement. A band admits every code c with lo <= c <= hi, and both ends are included.
- R5: A write that arrives while 6 entries are stored is refused. It leaves the table unchanged and gives the same one-cycle wr_err pulse.
- R6: pass is the OR over all stored entries, mixing single entries and bands. A code that matches no entry is rejected.
- R7: After reset or clr the table is empty and every code is rejected. When clr and wr_en are high in the same cycle, the clear wins, the write is dropped and no wr_err follows.
- R8: pass_vld is high exactly in the cycle after a cycle with code_vld high. pass is judged against the table as it stood when the strobe was sampled. pass is low whenever pass_vld is low.
- R9: For rd_idx below the entry count, rd_valid=1. rd_range is 1 for a band and 0 for a single entry, and rd_lo and rd_hi give the bounds, with rd_hi equal to rd_lo for a single entry. For any other rd_idx, all four read outputs are 0. The read port is combinational.
- R10: An accepted write never raises wr_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Empty the table |
| wr_en | input | 1 | Write one entry |
| wr_rng | input | 1 | 1 = band entry, 0 = single entry |
| wr_lo | input | 16 | Single code, or lower bound of a band |
| wr_hi | input | 16 | Upper bound of a band (ignored for a single entry) |
| wr_err | output | 1 | One-cycle pulse after a refused write |
| code_vld | input | 1 | Code strobe |
| code_in | input | 16 | Signed code to judge |
| pass_vld | output | 1 | Decision valid |
| pass | output | 1 | 1 = admit the code to the queue |
| rd_idx | input | 3 | Slot to read |
| rd_valid | output | 1 | Slot is occupied |
| rd_range | output | 1 | Type bit of the slot: 1 = band |
| rd_lo | output | 16 | Lower bound or single code of the slot |
| rd_hi | output | 16 | Upper bound of the slot |

## Verification
Every code from -600 to 600 is swept against a mixed table. The table holds two negative bands, a positive single code and a negative single code, so the sweep separates the inclusive band edges from the codes just outside them. It also separates exact matches from their neighbours and shows whether matching is signed. A second table adds a band that reaches +32767 and a single entry at -32768, which tests the two's-complement extremes. Refused writes (equal bounds, reversed bounds, a seventh entry) are followed by read-back and by a probe of the refused code, so a refused write that still altered the table would show. An empty table is swept after reset, and again after a clear issued in the same cycle as a write.

// File: rtl/evgate_pkg.sv
package evgate_pkg;
    parameter int CODE_W = 16;

    typedef logic signed [CODE_W-1:0] code_t;

    typedef struct packed {
        logic  used;
        logic  is_rng;
        code_t lo;
        code_t hi;
    } slot_t;

    // True when a stored slot admits the code.
    function automatic logic slot_hit(slot_t s, code_t c);
        if (!s.used)  return 1'b0;
        if (s.is_rng) return (c >= s.lo) && (c <= s.hi);
        return c == s.lo;
    endfunction

    // Band bounds must be strictly ordered; single codes always pass.
    function automatic logic bounds_ok(logic is_rng, code_t lo, code_t hi);
        return !is_rng || (lo < hi);
    endfunction
endpackage

// File: rtl/evgate_table.sv
module evgate_table
    import evgate_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   wr_en,
    input  logic                   wr_rng,
    input  code_t                  wr_lo,
    input  code_t                  wr_hi,
    output logic                   wr_err,
    output slot_t [DEPTH-1:0]      slots,
    output logic [CNT_W-1:0]       fill
);
    logic full;
    logic accept;
    logic refuse;

    assign full   = (fill == CNT_W'(DEPTH));
    assign accept = wr_en && !clr && !full && bounds_ok(wr_rng, wr_lo, wr_hi);
    assign refuse = wr_en && !clr && !accept;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fill   <= '0;
            wr_err <= 1'b0;
        end else begin
            wr_err <= refuse;
            if (accept) fill <= fill + 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                slots[i] <= '0;
            end else if (accept && fill == CNT_W'(i)) begin
                slots[i].used   <= 1'b1;
                slots[i].is_rng <= wr_rng;
                slots[i].lo     <= wr_lo;
                slots[i].hi     <= wr_rng ? wr_hi : wr_lo;
            end
        end
    end
endmodule

// File: rtl/evgate_match.sv
module evgate_match
    import evgate_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_t [DEPTH-1:0] slots,
    input  logic              code_vld,
    input  code_t             code_in,
    output logic              pass_vld,
    output logic              pass
);
    logic [DEPTH-1:0] hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit[i] = slot_hit(slots[i], code_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pass_vld <= 1'b0;
            pass     <= 1'b0;
        end else begin
            pass_vld <= code_vld;
            pass     <= code_vld && (|hit);
        end
    end
endmodule

// File: rtl/evgate_filter.sv
module evgate_filter
    import evgate_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic              wr_rng,
    input  logic [CODE_W-1:0] wr_lo,
    input  logic [CODE_W-1:0] wr_hi,
    output logic              wr_err,
    input  logic              code_vld,
    input  logic [CODE_W-1:0] code_in,
    output logic              pass_vld,
    output logic              pass,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_range,
    output logic [CODE_W-1:0] rd_lo,
    output logic [CODE_W-1:0] rd_hi
);
    slot_t [DEPTH-1:0] slots;
    logic [CNT_W-1:0]  fill;
    slot_t             rd_slot;

    evgate_table #(.DEPTH(DEPTH)) u_table (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .wr_en  (wr_en),
        .wr_rng (wr_rng),
        .wr_lo  (code_t'(wr_lo)),
        .wr_hi  (code_t'(wr_hi)),
        .wr_err (wr_err),
        .slots  (slots),
        .fill   (fill)
    );

    evgate_match #(.DEPTH(DEPTH)) u_match (
        .clk      (clk),
        .rst      (rst),
        .slots    (slots),
        .code_vld (code_vld),
        .code_in  (code_t'(code_in)),
        .pass_vld (pass_vld),
        .pass     (pass)
    );

    // Read mux: unused slots are held at zero, so an idle index reads zero.
    always_comb begin
        rd_slot = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) rd_slot = slots[i];
        end
    end

    assign rd_valid = rd_slot.used;
    assign rd_range = rd_slot.is_rng;
    assign rd_lo    = rd_slot.lo;
    assign rd_hi    = rd_slot.hi;
endmodule

// File: rtl/evgate_filter_chk.sv
module evgate_filter_chk
    import evgate_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              clr,
    input logic              wr_en,
    input logic              wr_rng,
    input logic [CODE_W-1:0] wr_lo,
    input logic [CODE_W-1:0] wr_hi,
    input logic              wr_err,
    input logic              code_vld,
    input logic              pass_vld,
    input logic              pass,
    input logic [CNT_W-1:0]  fill
);
    a_r1_cap: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(DEPTH));

    a_r3_bad_band: assert property (@(posedge clk) disable iff (rst)
        wr_en && !clr && wr_rng && ($signed(wr_lo) >= $signed(wr_hi))
        |=> wr_err && fill == $past(fill));

    a_r5_full: assert property (@(posedge clk) disable iff (rst)
        wr_en && !clr && fill == CNT_W'(DEPTH)
        |=> wr_err && fill == CNT_W'(DEPTH));

    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> fill == '0 && !wr_err);

    a_r7_empty_rejects: assert property (@(posedge clk) disable iff (rst)
        code_vld && fill == '0 && !wr_en |=> !pass);

    a_r8_strobe: assert property (@(posedge clk) disable iff (rst)
        code_vld |=> pass_vld);

    a_r8_idle: assert property (@(posedge clk) disable iff (rst)
        !code_vld |=> !pass_vld);

    a_r8_gate: assert property (@(posedge clk) disable iff (rst)
        !pass_vld |-> !pass);

    a_r10_accept: assert property (@(posedge clk) disable iff (rst)
        wr_en && !clr && fill < CNT_W'(DEPTH)
        && (!wr_rng || ($signed(wr_lo) < $signed(wr_hi)))
        |=> !wr_err && fill == $past(fill) + 1'b1);
endmodule

bind evgate_filter evgate_filter_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .wr_en    (wr_en),
    .wr_rng   (wr_rng),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wr_err   (wr_err),
    .code_vld (code_vld),
    .pass_vld (pass_vld),
    .pass     (pass),
    .fill     (fill)
);

// File: tb/evgate_filter_test.sv
module evgate_filter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_rng = 1'b0;
    logic [15:0] wr_lo = '0;
    logic [15:0] wr_hi = '0;
    logic        wr_err;
    logic        code_vld = 1'b0;
    logic [15:0] code_in = '0;
    logic        pass_vld;
    logic        pass;
    logic [2:0]  rd_idx = '0;
    logic        rd_valid;
    logic        rd_range;
    logic [15:0] rd_lo;
    logic [15:0] rd_hi;

    int checks = 0;
    int errors = 0;

    int m_n = 0;
    int m_rng [6];
    int m_lo  [6];
    int m_hi  [6];

    evgate_filter uut (
        .clk(clk), .rst(rst), .clr(clr),
        .wr_en(wr_en), .wr_rng(wr_rng), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_err(wr_err),
        .code_vld(code_vld), .code_in(code_in),
        .pass_vld(pass_vld), .pass(pass),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_range(rd_range),
        .rd_lo(rd_lo), .rd_hi(rd_hi)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit model_pass(int c);
        for (int i = 0; i < m_n; i++) begin
            if (m_rng[i] != 0) begin
                if (c >= m_lo[i] && c <= m_hi[i]) return 1'b1;
            end else if (c == m_lo[i]) begin
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    task automatic probe(input int c, input string req);
        int got;
        code_in  = 16'(c);
        code_vld = 1'b1;
        @(negedge clk);
        code_vld = 1'b0;
        got = int'(pass);
        chk(pass_vld === 1'b1, "R8 pass_vld after strobe", int'(pass_vld), 1);
        chk(pass === model_pass(c), req, got, int'(model_pass(c)));
    endtask

    task automatic sweep(input int lo, input int hi, input string req);
        for (int c = lo; c <= hi; c++) probe(c, req);
    endtask

    task automatic put(input bit rng, input int lo, input int hi, input bit exp_err, input string req);
        @(negedge clk);
        wr_en  = 1'b1;
        wr_rng = rng;
        wr_lo  = 16'(lo);
        wr_hi  = 16'(hi);
        @(negedge clk);
        wr_en = 1'b0;
        chk(wr_err === exp_err, req, int'(wr_err), int'(exp_err));
        if (!exp_err) begin
            m_rng[m_n] = int'(rng);
            m_lo[m_n]  = lo;
            m_hi[m_n]  = rng ? hi : lo;
            m_n++;
        end
        @(negedge clk);
        chk(wr_err === 1'b0, "R3 R5 wr_err is one cycle", int'(wr_err), 0);
    endtask

    task automatic readback(input string req);
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #1;
            if (i < m_n) begin
                chk(rd_valid === 1'b1, req, int'(rd_valid), 1);
                chk(int'(rd_range) == m_rng[i], req, int'(rd_range), m_rng[i]);
                chk(int'($signed(rd_lo)) == m_lo[i], req, int'($signed(rd_lo)), m_lo[i]);
                chk(int'($signed(rd_hi)) == m_hi[i], req, int'($signed(rd_hi)), m_hi[i]);
            end else begin
                chk(rd_valid === 1'b0 && rd_range === 1'b0 && rd_lo === '0 && rd_hi === '0,
                    req, int'(rd_valid), 0);
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R7: empty after reset
        chk(pass_vld === 1'b0 && pass === 1'b0, "R8 idle outputs after reset", int'(pass_vld), 0);
        chk(wr_err === 1'b0, "R7 no error after reset", int'(wr_err), 0);
        readback("R9 empty read after reset");
        sweep(-5, 5, "R7 empty table rejects");
        probe(-32768, "R7 empty table rejects");

        // R1 R2 R4 R6 R10: mixed table
        put(1'b1, -440, -410, 1'b0, "R10 accepted band write");
        put(1'b1, -258, -220, 1'b0, "R10 accepted band write");
        put(1'b0, 402, 0, 1'b0, "R10 accepted single write");
        put(1'b0, -110, 999, 1'b0, "R10 accepted single write");
        readback("R1 R9 slots in write order");
        sweep(-600, 600, "R2 R4 R6 mixed table sweep");

        // R3: bad bands are refused
        put(1'b1, 50, 50, 1'b1, "R3 equal bounds refused");
        put(1'b1, 100, -100, 1'b1, "R3 reversed bounds refused");
        readback("R3 table unchanged");
        probe(50, "R3 refused band not matched");
        probe(0, "R3 refused band not matched");

        // R4 R5: extremes then overflow
        put(1'b1, 32000, 32767, 1'b0, "R10 accepted band write");
        put(1'b0, -32768, 0, 1'b0, "R10 accepted single write");
        put(1'b0, 7, 0, 1'b1, "R5 seventh write refused");
        readback("R5 table unchanged when full");
        probe(7, "R5 refused seventh entry not matched");
        probe(32767, "R4 top of range inclusive");
        probe(32000, "R4 band low end inclusive");
        probe(31999, "R4 below band rejected");
        probe(-32768, "R4 most negative single code");
        probe(-32767, "R2 neighbour of single rejected");

        // R8: no strobe -> no valid
        @(negedge clk);
        chk(pass_vld === 1'b0 && pass === 1'b0, "R8 no strobe no valid", int'(pass_vld), 0);

        // R7: clear wins over a simultaneous write
        @(negedge clk);
        clr = 1'b1; wr_en = 1'b1; wr_rng = 1'b0; wr_lo = 16'd5;
        @(negedge clk);
        clr = 1'b0; wr_en = 1'b0;
        chk(wr_err === 1'b0, "R7 clear with write no error", int'(wr_err), 0);
        m_n = 0;
        readback("R7 table empty after clear");
        probe(5, "R7 dropped write not matched");
        sweep(-445, -405, "R7 cleared table rejects");
        probe(402, "R7 cleared table rejects");

        // R1: refill after clear starts at slot 0
        put(1'b0, 5, 0, 1'b0, "R10 accepted single write");
        readback("R1 refill at slot 0");
        sweep(3, 7, "R2 single after refill");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule